// File: doc/BRIEF.md
# Speculative Reorder Buffer with Mispredict Recovery

This block keeps program order for an out-of-order core. Each instruction takes an entry at the tail when it issues and gets the entry index back as its tag. Execution units return results on a tagged write-back port. The write-back marks the entry complete and stores the value. Two lookup ports let the issue logic read a result by tag before it has retired. Entries leave only from the head, and only once complete. A non-branch entry writes its destination register on retirement. A branch entry that was flagged as mispredicted empties the whole buffer and raises a one-cycle flush so that fetch can redirect.

A two-state controller governs the block. In state ST_RUN the buffer allocates and retires normally. The transition RUN_TO_REDIRECT fires when a flagged branch retires. In that same edge every entry is freed and both pointers return to zero. State ST_REDIRECT lasts exactly one cycle. During it the flush output is high and allocation is refused. The unconditional transition REDIRECT_TO_RUN then returns the controller to ST_RUN. Head and tail pointers carry an extra wrap bit, so full and empty can be told apart without a counter.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. alloc_ready is high, alloc_tag is 0, cm_valid and flush_o are low, and both lookup ports report not ready.
- R2: While DEPTH entries are held, alloc_ready is low, and an allocate request in that cycle is dropped.
- R3: Each accepted allocation gets the current tail index as its tag. Tags advance by one per accepted allocation and wrap from DEPTH-1 to 0. The number of busy entries always equals the pointer occupancy.
- R4: A write-back to a held entry marks it complete and stores wb_data. A write-back to a free entry leaves that entry not ready.
- R5: Only the head entry retires, and it retires in the same cycle that it is held and complete (cm_valid high). Younger complete entries wait behind an incomplete head.
- R6: The class encoding is 2'b00 ALU, 2'b01 memory, 2'b10 branch and 2'b11 system. A non-branch retirement drives cm_we high, with cm_dst and cm_data taken from the entry. A branch retirement drives cm_we low.
- R7: When a branch allocated with alloc_mispred high retires, the buffer is cleared at that edge. flush_o is then high for exactly the next cycle, and alloc_ready is low in that cycle. All entries read not ready, and the next accepted allocation gets tag 0. An allocation accepted in the retirement cycle is discarded.
- R8: A branch allocated with alloc_mispred low retires like any other entry, frees its slot and causes no flush.
- R9: A lookup port reports ready, with the stored result on its data output, when its tag names a held, complete entry. Otherwise it reports not ready.
- R10: An allocation and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests an entry |
| alloc_class | input | 2 | Instruction class (see R6) |
| alloc_dst | input | REG_W | Destination register number |
| alloc_mispred | input | 1 | Branch will be found mispredicted at retirement |
| alloc_ready | output | 1 | An entry can be taken this cycle |
| alloc_tag | output | IW | Tag given to the allocating instruction |
| wb_valid | input | 1 | Result write-back valid |
| wb_tag | input | IW | Entry the result belongs to |
| wb_data | input | DATA_W | Result value |
| rd_a_tag | input | IW | Lookup port A tag |
| rd_a_ready | output | 1 | Port A entry holds a result |
| rd_a_data | output | DATA_W | Port A result |
| rd_b_tag | input | IW | Lookup port B tag |
| rd_b_ready | output | 1 | Port B entry holds a result |
| rd_b_data | output | DATA_W | Port B result |
| cm_valid | output | 1 | Head entry retires this cycle |
| cm_we | output | 1 | Register file write enable for the retirement |
| cm_tag | output | IW | Tag of the retiring entry |
| cm_dst | output | REG_W | Register written on retirement |
| cm_data | output | DATA_W | Value written on retirement |
| flush_o | output | 1 | One-cycle flush and redirect |

## Verification
The bench goes after four cases. The first is a younger result finishing before the head; a design that retired on any ready entry would emit registers out of order. The second is a full buffer with an issue request pending; a design that compared pointers without the wrap bit would see an empty buffer and overwrite the oldest entry. The third is retiring and allocating together, both at the full point and below it; a design that let one operation block the other would lose a slot or stall. The last is a mispredicted branch with complete younger work behind it and an allocation in the same cycle; a design that flushed late or only partly would retire squashed results, keep stale lookups ready, or hand out a nonzero tag after recovery.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'b00,
        CLS_MEM    = 2'b01,
        CLS_BRANCH = 2'b10,
        CLS_SYS    = 2'b11
    } op_class_e;

    typedef enum logic {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } rob_state_e;

endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx_o,
    output logic          wrap_o
);

    logic [IW-1:0] idx_q;
    logic          wrap_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx_q  <= '0;
            wrap_q <= 1'b0;
        end else if (adv) begin
            if (idx_q == IW'(DEPTH - 1)) begin
                idx_q  <= '0;
                wrap_q <= ~wrap_q;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idx_o  = idx_q;
    assign wrap_o = wrap_q;

endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc_en,
    input  logic [IW-1:0]     alloc_idx,
    input  op_class_e         alloc_cls,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic              alloc_mis,
    input  logic              wb_en,
    input  logic [IW-1:0]     wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              free_en,
    input  logic [IW-1:0]     free_idx,
    output logic [DEPTH-1:0]  busy_o,
    output logic [DEPTH-1:0]  rdy_o,
    output logic [DEPTH-1:0]  mis_o,
    output op_class_e         cls_o [DEPTH],
    output logic [REG_W-1:0]  dst_o [DEPTH],
    output logic [DATA_W-1:0] val_o [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic              busy_q;
        logic              rdy_q;
        logic              mis_q;
        op_class_e         cls_q;
        logic [REG_W-1:0]  dst_q;
        logic [DATA_W-1:0] val_q;

        logic hit_alloc;
        logic hit_free;
        logic hit_wb;

        assign hit_alloc = alloc_en && (alloc_idx == IW'(g));
        assign hit_free  = free_en  && (free_idx  == IW'(g));
        assign hit_wb    = wb_en    && (wb_idx    == IW'(g)) && busy_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q <= 1'b0;
                rdy_q  <= 1'b0;
                mis_q  <= 1'b0;
                cls_q  <= CLS_ALU;
                dst_q  <= '0;
                val_q  <= '0;
            end else if (clr) begin
                busy_q <= 1'b0;
                rdy_q  <= 1'b0;
            end else if (hit_alloc) begin
                busy_q <= 1'b1;
                rdy_q  <= 1'b0;
                mis_q  <= alloc_mis;
                cls_q  <= alloc_cls;
                dst_q  <= alloc_dst;
            end else if (hit_free) begin
                busy_q <= 1'b0;
                rdy_q  <= 1'b0;
            end else if (hit_wb) begin
                rdy_q  <= 1'b1;
                val_q  <= wb_data;
            end
        end

        assign busy_o[g] = busy_q;
        assign rdy_o[g]  = rdy_q;
        assign mis_o[g]  = mis_q;
        assign cls_o[g]  = cls_q;
        assign dst_o[g]  = dst_q;
        assign val_o[g]  = val_q;
    end

endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [IW-1:0]     tag_i,
    input  logic [DEPTH-1:0]  busy_i,
    input  logic [DEPTH-1:0]  rdy_i,
    input  logic [DATA_W-1:0] val_i [DEPTH],
    output logic              ready_o,
    output logic [DATA_W-1:0] data_o
);

    always_comb begin
        ready_o = 1'b0;
        data_o  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (tag_i == IW'(i)) begin
                ready_o = busy_i[i] && rdy_i[i];
                data_o  = val_i[i];
            end
        end
    end

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mispred_commit,
    output logic run_o,
    output logic flush_o
);

    rob_state_e state_q;
    rob_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (mispred_commit) state_d = ST_REDIRECT;
            ST_REDIRECT: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN: begin
                run_o   = 1'b1;
                flush_o = 1'b0;
            end
            ST_REDIRECT: begin
                run_o   = 1'b0;
                flush_o = 1'b1;
            end
            default: begin
                run_o   = 1'b0;
                flush_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_class,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic              alloc_mispred,
    output logic              alloc_ready,
    output logic [IW-1:0]     alloc_tag,
    input  logic              wb_valid,
    input  logic [IW-1:0]     wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IW-1:0]     rd_a_tag,
    output logic              rd_a_ready,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IW-1:0]     rd_b_tag,
    output logic              rd_b_ready,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              cm_valid,
    output logic              cm_we,
    output logic [IW-1:0]     cm_tag,
    output logic [REG_W-1:0]  cm_dst,
    output logic [DATA_W-1:0] cm_data,
    output logic              flush_o
);

    logic [IW-1:0]     head_idx;
    logic [IW-1:0]     tail_idx;
    logic              head_wrap;
    logic              tail_wrap;
    logic              run;
    logic              full;
    logic              alloc_fire;
    logic              head_ok;
    logic              head_is_br;
    logic              mispred_commit;

    logic [DEPTH-1:0]  ent_busy;
    logic [DEPTH-1:0]  ent_rdy;
    logic [DEPTH-1:0]  ent_mis;
    op_class_e         ent_cls [DEPTH];
    logic [REG_W-1:0]  ent_dst [DEPTH];
    logic [DATA_W-1:0] ent_val [DEPTH];

    assign full           = (head_idx == tail_idx) && (head_wrap != tail_wrap);
    assign alloc_ready    = run && !full;
    assign alloc_fire     = alloc_valid && alloc_ready;
    assign alloc_tag      = tail_idx;

    assign head_ok        = run && ent_busy[head_idx] && ent_rdy[head_idx];
    assign head_is_br     = (ent_cls[head_idx] == CLS_BRANCH);
    assign mispred_commit = head_ok && head_is_br && ent_mis[head_idx];

    assign cm_valid       = head_ok;
    assign cm_we          = head_ok && !head_is_br;
    assign cm_tag         = head_idx;
    assign cm_dst         = ent_dst[head_idx];
    assign cm_data        = ent_val[head_idx];

    rob_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .mispred_commit (mispred_commit),
        .run_o          (run),
        .flush_o        (flush_o)
    );

    rob_ptr #(.DEPTH(DEPTH)) u_head (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mispred_commit),
        .adv    (head_ok),
        .idx_o  (head_idx),
        .wrap_o (head_wrap)
    );

    rob_ptr #(.DEPTH(DEPTH)) u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mispred_commit),
        .adv    (alloc_fire),
        .idx_o  (tail_idx),
        .wrap_o (tail_wrap)
    );

    rob_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .REG_W  (REG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mispred_commit),
        .alloc_en  (alloc_fire),
        .alloc_idx (tail_idx),
        .alloc_cls (op_class_e'(alloc_class)),
        .alloc_dst (alloc_dst),
        .alloc_mis (alloc_mispred),
        .wb_en     (wb_valid),
        .wb_idx    (wb_tag),
        .wb_data   (wb_data),
        .free_en   (head_ok),
        .free_idx  (head_idx),
        .busy_o    (ent_busy),
        .rdy_o     (ent_rdy),
        .mis_o     (ent_mis),
        .cls_o     (ent_cls),
        .dst_o     (ent_dst),
        .val_o     (ent_val)
    );

    rob_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_look_a (
        .tag_i   (rd_a_tag),
        .busy_i  (ent_busy),
        .rdy_i   (ent_rdy),
        .val_i   (ent_val),
        .ready_o (rd_a_ready),
        .data_o  (rd_a_data)
    );

    rob_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_look_b (
        .tag_i   (rd_b_tag),
        .busy_i  (ent_busy),
        .rdy_i   (ent_rdy),
        .val_i   (ent_val),
        .ready_o (rd_b_ready),
        .data_o  (rd_b_data)
    );

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             cm_valid,
    input logic             cm_we,
    input logic             flush_o,
    input logic [IW-1:0]    head_idx,
    input logic [IW-1:0]    tail_idx,
    input logic             head_wrap,
    input logic             tail_wrap,
    input logic [DEPTH-1:0] busy
);

    int  occ;
    logic ptr_full;
    logic ptr_empty;

    always_comb begin
        if (head_wrap == tail_wrap) occ = int'(tail_idx) - int'(head_idx);
        else                        occ = DEPTH - int'(head_idx) + int'(tail_idx);
    end

    assign ptr_full  = (head_idx == tail_idx) && (head_wrap != tail_wrap);
    assign ptr_empty = (head_idx == tail_idx) && (head_wrap == tail_wrap);

    p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_full |-> !alloc_ready);

    p_occupancy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy) == occ);

    p_commit_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> !ptr_empty);

    p_flush_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (busy == '0) && ptr_empty && (head_idx == '0));

    p_flush_blocks_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !alloc_ready);

    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) |-> $past(cm_valid && !cm_we));

endmodule

bind rob_core rob_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .cm_valid    (cm_valid),
    .cm_we       (cm_we),
    .flush_o     (flush_o),
    .head_idx    (head_idx),
    .tail_idx    (tail_idx),
    .head_wrap   (head_wrap),
    .tail_wrap   (tail_wrap),
    .busy        (ent_busy)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;

    localparam int CLK_PERIOD = 10;
    localparam int HALF   = CLK_PERIOD / 2;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 32;
    localparam int REG_W  = 5;
    localparam int IW     = 3;
    localparam logic [1:0] C_ALU = 2'b00;
    localparam logic [1:0] C_MEM = 2'b01;
    localparam logic [1:0] C_BR  = 2'b10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alloc_valid;
    logic [1:0]        alloc_class;
    logic [REG_W-1:0]  alloc_dst;
    logic              alloc_mispred;
    logic              alloc_ready;
    logic [IW-1:0]     alloc_tag;
    logic              wb_valid;
    logic [IW-1:0]     wb_tag;
    logic [DATA_W-1:0] wb_data;
    logic [IW-1:0]     rd_a_tag;
    logic              rd_a_ready;
    logic [DATA_W-1:0] rd_a_data;
    logic [IW-1:0]     rd_b_tag;
    logic              rd_b_ready;
    logic [DATA_W-1:0] rd_b_data;
    logic              cm_valid;
    logic              cm_we;
    logic [IW-1:0]     cm_tag;
    logic [REG_W-1:0]  cm_dst;
    logic [DATA_W-1:0] cm_data;
    logic              flush_o;

    always #(HALF) clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_class(alloc_class), .alloc_dst(alloc_dst),
        .alloc_mispred(alloc_mispred), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .rd_a_tag(rd_a_tag), .rd_a_ready(rd_a_ready), .rd_a_data(rd_a_data),
        .rd_b_tag(rd_b_tag), .rd_b_ready(rd_b_ready), .rd_b_data(rd_b_data),
        .cm_valid(cm_valid), .cm_we(cm_we), .cm_tag(cm_tag), .cm_dst(cm_dst),
        .cm_data(cm_data), .flush_o(flush_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [REG_W-1:0]  dst;
        logic [DATA_W-1:0] data;
        bit                we;
        bit                squash;
    } item_t;
    item_t sb_q[$];

    bit                m_busy [DEPTH];
    bit                m_rdy  [DEPTH];
    bit                m_br   [DEPTH];
    bit                m_mis  [DEPTH];
    logic [DATA_W-1:0] m_val  [DEPTH];
    logic [DATA_W-1:0] m_plan [DEPTH];
    int                m_head = 0;
    int                m_tail = 0;
    int                m_cnt  = 0;
    bit                m_fl   = 1'b0;

    task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, check just before the rising edge,
    // then advance the reference model at the rising edge.
    task automatic step(input bit av, input logic [1:0] cls, input logic [REG_W-1:0] dst,
                        input bit mis, input logic [DATA_W-1:0] val,
                        input bit wv, input int wtag,
                        input bit lk = 1'b0, input int ra = 0, input int rb = 0,
                        input string lreq = "R9");
        bit exp_ar, exp_cm, nfl;
        alloc_valid   = av;
        alloc_class   = cls;
        alloc_dst     = dst;
        alloc_mispred = mis;
        wb_valid      = wv;
        wb_tag        = IW'(wtag);
        wb_data       = m_plan[wtag];
        rd_a_tag      = IW'(ra);
        rd_b_tag      = IW'(rb);
        #(HALF - 2);
        exp_ar = !m_fl && (m_cnt < DEPTH);
        exp_cm = !m_fl && m_busy[m_head] && m_rdy[m_head];
        chk(32'(alloc_ready), 32'(exp_ar), "R2", "alloc_ready");
        if (exp_ar) chk(32'(alloc_tag), 32'(m_tail), "R3", "alloc_tag");
        chk(32'(cm_valid), 32'(exp_cm), "R5", "cm_valid");
        chk(32'(flush_o), 32'(m_fl), "R7", "flush_o");
        if (exp_cm) chk(32'(cm_we), 32'(!m_br[m_head]), "R6", "cm_we");
        if (lk) begin
            chk(32'(rd_a_ready), 32'(m_busy[ra] && m_rdy[ra]), lreq, "rd_a_ready");
            if (m_busy[ra] && m_rdy[ra]) chk(rd_a_data, m_val[ra], lreq, "rd_a_data");
            chk(32'(rd_b_ready), 32'(m_busy[rb] && m_rdy[rb]), lreq, "rd_b_ready");
            if (m_busy[rb] && m_rdy[rb]) chk(rd_b_data, m_val[rb], lreq, "rd_b_data");
        end
        nfl = exp_cm && m_br[m_head] && m_mis[m_head];
        if (av && exp_ar && !nfl)
            sb_q.push_back('{dst: dst, data: val, we: (cls != C_BR), squash: (cls == C_BR) && mis});
        @(posedge clk);
        if (nfl) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_busy[i] = 1'b0;
                m_rdy[i]  = 1'b0;
            end
            m_head = 0;
            m_tail = 0;
            m_cnt  = 0;
        end else begin
            if (wv && m_busy[wtag]) begin
                m_rdy[wtag] = 1'b1;
                m_val[wtag] = m_plan[wtag];
            end
            if (exp_cm) begin
                m_busy[m_head] = 1'b0;
                m_rdy[m_head]  = 1'b0;
                m_head = (m_head + 1) % DEPTH;
                m_cnt--;
            end
            if (av && exp_ar) begin
                m_busy[m_tail] = 1'b1;
                m_rdy[m_tail]  = 1'b0;
                m_br[m_tail]   = (cls == C_BR);
                m_mis[m_tail]  = mis;
                m_plan[m_tail] = val;
                m_tail = (m_tail + 1) % DEPTH;
                m_cnt++;
            end
        end
        m_fl = nfl;
        @(negedge clk);
        alloc_valid = 1'b0;
        wb_valid    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, C_ALU, '0, 1'b0, '0, 1'b0, 0);
    endtask

    task automatic alloc(input logic [1:0] cls, input logic [REG_W-1:0] dst,
                         input bit mis, input logic [DATA_W-1:0] val);
        step(1'b1, cls, dst, mis, val, 1'b0, 0);
    endtask

    task automatic wb(input int t);
        step(1'b0, C_ALU, '0, 1'b0, '0, 1'b1, t);
    endtask

    // Write back every pending entry, youngest first, so the head completes last.
    task automatic wb_pending();
        int h, c;
        h = m_head;
        c = m_cnt;
        for (int k = c - 1; k >= 0; k--) begin
            int t;
            t = (h + k) % DEPTH;
            if (m_busy[t] && !m_rdy[t]) wb(t);
        end
    endtask

    // Monitor: pops the scoreboard whenever an entry retires.
    initial begin
        forever begin
            @(negedge clk);
            #(HALF - 1);
            if (rst_n === 1'b1 && cm_valid === 1'b1) begin
                if (sb_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R5 unexpected retirement: actual tag %0d expected none", cm_tag);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(32'(cm_we), 32'(it.we), "R6", "retire cm_we");
                    if (it.we) begin
                        chk(32'(cm_dst), 32'(it.dst), "R6", "retire cm_dst");
                        chk(cm_data, it.data, "R5", "retire order data");
                    end
                    if (it.squash) sb_q.delete();
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        alloc_valid = 1'b0; alloc_class = C_ALU; alloc_dst = '0; alloc_mispred = 1'b0;
        wb_valid = 1'b0; wb_tag = '0; wb_data = '0; rd_a_tag = '0; rd_b_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            m_busy[i] = 1'b0; m_rdy[i] = 1'b0; m_br[i] = 1'b0; m_mis[i] = 1'b0;
            m_val[i] = '0; m_plan[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty state after reset
        chk(32'(alloc_ready), 32'd1, "R1", "alloc_ready");
        chk(32'(alloc_tag),   32'd0, "R1", "alloc_tag");
        chk(32'(cm_valid),    32'd0, "R1", "cm_valid");
        chk(32'(flush_o),     32'd0, "R1", "flush_o");
        chk(32'(rd_a_ready),  32'd0, "R1", "rd_a_ready");
        chk(32'(rd_b_ready),  32'd0, "R1", "rd_b_ready");
        @(negedge clk);

        // R3 R5 R9: out-of-order completion, in-order retirement
        alloc(C_ALU, 5'd3, 1'b0, 32'hA000_0000);
        alloc(C_MEM, 5'd4, 1'b0, 32'hA000_0001);
        alloc(C_ALU, 5'd5, 1'b0, 32'hA000_0002);
        wb(2);
        step(1'b0, C_ALU, '0, 1'b0, '0, 1'b0, 0, 1'b1, 2, 1);
        wb(1);
        step(1'b0, C_ALU, '0, 1'b0, '0, 1'b0, 0, 1'b1, 1, 0);
        wb(0);
        idle(4);

        // R2: fill to DEPTH, then a refused request
        for (int i = 0; i < DEPTH; i++) alloc(C_ALU, 5'(8 + i), 1'b0, 32'hB000_0000 + 32'(i));
        alloc(C_ALU, 5'd30, 1'b0, 32'hBAD0_0000);
        wb_pending();
        // R10: retire at the full point, then retire and allocate together
        for (int i = 0; i < 4; i++) alloc(C_MEM, 5'(20 + i), 1'b0, 32'hC000_0000 + 32'(i));
        wb_pending();
        idle(10);

        // R4: write-back to a free entry is dropped
        m_plan[5] = 32'hDEAD_BEEF;
        wb(5);
        step(1'b0, C_ALU, '0, 1'b0, '0, 1'b0, 0, 1'b1, 5, 5, "R4");

        // R8: correctly predicted branch retires quietly
        alloc(C_BR, 5'd0, 1'b0, 32'h0000_0B0B);
        alloc(C_ALU, 5'd7, 1'b0, 32'hD000_0007);
        wb_pending();
        idle(4);

        // R7: mispredicted branch with complete younger work and a same-cycle allocation
        begin
            int bt;
            bt = m_tail;
            alloc(C_BR, 5'd0, 1'b1, 32'h0000_0F0F);
            alloc(C_ALU, 5'd9, 1'b0, 32'hE000_0001);
            alloc(C_ALU, 5'd10, 1'b0, 32'hE000_0002);
            wb((bt + 2) % DEPTH);
            wb((bt + 1) % DEPTH);
            wb(bt);
            alloc(C_ALU, 5'd11, 1'b0, 32'hE000_0003);
            step(1'b1, C_ALU, 5'd12, 1'b0, 32'hE000_0004, 1'b0, 0,
                 1'b1, (bt + 1) % DEPTH, (bt + 2) % DEPTH, "R7");
        end
        alloc(C_ALU, 5'd13, 1'b0, 32'hF000_0000);
        wb(0);
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule